// File: doc/BRIEF.md
# Display Buffer Bulk-Operation Engine

This block performs bulk operations on a 4K-byte character buffer and a same-sized attribute buffer that sit behind one single-port memory. A 12-bit cursor selects the location being worked on. Before raising `start`, a controller places an operation code and its operands on the input pins. The operands are a compare pattern, a compare mask, an attribute mask, a data byte and a burst-length select. The engine then walks the memory until the operation's stop rule is met.

The supported operations are:
- masked search, forward or backward;
- masked clear, which also scrubs the attribute beside each cleared byte;
- insert, which ripples the existing bytes one place toward higher addresses;
- attribute write under mask;
- a short or long burst read that streams bytes out.

Every memory step uses a request/grant handshake. A read step is followed by a write step where the operation needs one. `busy`, `modified` and a one-cycle `done` pulse report progress.

The memory is addressed by `mem_addr` plus a plane select. `mem_attr`=0 selects the character buffer and `mem_attr`=1 selects the attribute buffer. A granted access takes effect at the clock edge where `mem_req` and `mem_gnt` are both high. Read data is valid on `mem_rdata` in the following cycle.

Top module: `bufop_engine`

## Requirements
- R1: After synchronous reset, `busy`, `modified`, `done`, `mem_req` and `rd_valid` are low and `cursor` is 0.
- R2: While idle, `ld_addr` loads `ld_addr_val` into the cursor at the next edge. While busy, `ld_addr` has no effect.
- R3: A `start` is accepted only while idle, with `cmd` 0 = clear, 1 = search forward, 2 = search backward, 3 = insert, 4 = attribute write under mask, 5 = burst read. A `start` while busy, or with `cmd` 6 or 7, is ignored.
- R4: A location matches when `(byte XOR pattern) AND mask` is zero. A mask of 0 therefore matches any byte.
- R5: Clear writes 0 to each character location from the cursor onward. It stops at the first matching location, which is left unchanged and becomes the cursor.
- R6: Clear replaces the attribute beside each cleared byte with `attribute AND NOT attr_mask`. If nothing matches, clear stops once the cursor wraps to 0.
- R7: Search forward leaves the cursor at the first match at or above the start. If the cursor wraps without a match, it ends at 0.
- R8: Search backward leaves the cursor at the first match at or below the start. If location 0 does not match, the cursor ends at 0xFFF.
- R9: Insert writes `attr_mask` to the attribute at the start location and `wr_data` to the character there. Each displaced byte moves one location up. The ripple stops after the location whose old byte was 0x00 has been overwritten, and the cursor returns to the start location.
- R10: If insert reaches location 0xFFF without finding a null byte, the byte pushed out of 0xFFF is dropped and location 0 is not written.
- R11: Attribute write under mask stores `(NOT attr_mask AND old attribute) OR wr_data` at the cursor, then advances the cursor by one.
- R12: Burst read puts one byte per location on `rd_data` with a `rd_valid` pulse and advances the cursor after each byte. It stops when the cursor's low 2 bits (`rm_long`=0) or low 5 bits (`rm_long`=1) become zero.
- R13: `busy` is high from the edge that accepts a start until the cycle after `done`. `done` pulses for exactly one cycle at the end of each accepted operation. `modified` is high during clear, insert and attribute write, and it is low in the `done` cycle.
- R14: Once raised, `mem_req` stays high with address, plane and write enable unchanged until `mem_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the operation on `cmd` |
| cmd | input | 3 | Operation code |
| pattern | input | 8 | Compare pattern |
| mask | input | 8 | Compare mask, 1 = bit compared |
| attr_mask | input | 8 | Attribute mask / inserted attribute |
| wr_data | input | 8 | Insert byte or attribute OR value |
| rm_long | input | 1 | Burst read group: 0 = 4, 1 = 32 |
| ld_addr | input | 1 | Load cursor while idle |
| ld_addr_val | input | 12 | Cursor load value |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory access grant |
| mem_we | output | 1 | Access is a write |
| mem_attr | output | 1 | Plane select: 1 = attribute buffer |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, the cycle after a granted read |
| rd_valid | output | 1 | Burst read byte valid |
| rd_data | output | 8 | Burst read byte |
| busy | output | 1 | Operation in progress |
| modified | output | 1 | Buffer-modifying operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cursor | output | 12 | Buffer address counter |

## Verification
The following hold on every cycle and are checked continuously:
- the handshake discipline, where a request stays stable until granted;
- the one-cycle `done` pulse and the return to idle after it;
- the nesting of `modified` and `rd_valid` inside `busy`;
- command registers held stable during an operation;
- the cursor holding still when not stepped.

The following can only be shown by directed scenarios against a modelled memory with a stalling grant:
- the data-dependent stop rules: masked matches, the wrap to 0, the 0xFFF end of a backward search, and a ripple that ends at a null byte or at the top of the buffer;
- the attribute formulas and the bytes streamed by a burst read.

// File: rtl/bufop_pkg.sv
package bufop_pkg;

    localparam int DW = 8;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [2:0] {
        OP_CLEAR  = 3'd0,
        OP_SFWD   = 3'd1,
        OP_SBWD   = 3'd2,
        OP_INSERT = 3'd3,
        OP_WUM    = 3'd4,
        OP_RDMULT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_BRD, S_BEVAL, S_BWR, S_ARD, S_AEVAL, S_AWR, S_FIN
    } state_e;

    typedef enum logic [1:0] {
        CT_HOLD, CT_INC, CT_DEC, CT_LOAD
    } ctr_op_e;

    typedef struct packed {
        op_e   op;
        byte_t pattern;
        byte_t mask;
        byte_t amask;
        byte_t data;
        logic  rm_long;
    } job_t;

    function automatic logic op_known(logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic op_modifies(op_e o);
        return (o == OP_CLEAR) || (o == OP_INSERT) || (o == OP_WUM);
    endfunction

    function automatic byte_t wum_merge(byte_t old_attr, byte_t m, byte_t d);
        return (~m & old_attr) | d;
    endfunction

    function automatic byte_t attr_scrub(byte_t old_attr, byte_t m);
        return old_attr & ~m;
    endfunction

endpackage

// File: rtl/bufop_cursor.sv
module bufop_cursor
    import bufop_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  ctr_op_e           op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            case (op)
                CT_INC:  cur <= cur + ADDR_W'(1);
                CT_DEC:  cur <= cur - ADDR_W'(1);
                CT_LOAD: cur <= load_val;
                default: cur <= cur;
            endcase
        end
    end

    // R2: the counter moves only when told to
    assert_cursor_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (op == CT_HOLD) |=> $stable(cur));

    // R7: stepping up from the top address wraps to zero
    assert_cursor_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (op == CT_INC && cur == {ADDR_W{1'b1}}) |=> (cur == '0));

endmodule

// File: rtl/bufop_match.sv
module bufop_match
    import bufop_pkg::*;
(
    input  byte_t data,
    input  byte_t pattern,
    input  byte_t mask,
    input  byte_t old_byte,
    output logic  hit,
    output logic  old_null
);

    logic [DW-1:0] diff;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign diff[i] = mask[i] & (data[i] ^ pattern[i]);
    end

    assign hit      = ~|diff;
    assign old_null = ~|old_byte;

endmodule

// File: rtl/bufop_engine.sv
module bufop_engine
    import bufop_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int RM_SHORT_W = 2,
    parameter int RM_LONG_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [7:0]        pattern,
    input  logic [7:0]        mask,
    input  logic [7:0]        attr_mask,
    input  logic [7:0]        wr_data,
    input  logic              rm_long,
    input  logic              ld_addr,
    input  logic [ADDR_W-1:0] ld_addr_val,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic              mem_attr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              modified,
    output logic              done,
    output logic [ADDR_W-1:0] cursor
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    state_e            state_q, state_d;
    job_t              job_q, job_d;
    byte_t             carry_q, carry_d;
    byte_t             old_q, old_d;
    byte_t             hold_q, hold_d;
    logic [ADDR_W-1:0] start_q, start_d;
    ctr_op_e           ctr_op;
    logic [ADDR_W-1:0] ctr_val;
    logic              hit, old_null, grp_end;

    bufop_cursor #(.ADDR_W(ADDR_W)) u_cursor (
        .clk      (clk),
        .rst      (rst),
        .op       (ctr_op),
        .load_val (ctr_val),
        .cur      (cursor)
    );

    bufop_match u_match (
        .data     (mem_rdata),
        .pattern  (job_q.pattern),
        .mask     (job_q.mask),
        .old_byte (old_q),
        .hit      (hit),
        .old_null (old_null)
    );

    assign grp_end = job_q.rm_long ? (&cursor[RM_LONG_W-1:0])
                                   : (&cursor[RM_SHORT_W-1:0]);

    always_comb begin
        state_d   = state_q;
        job_d     = job_q;
        carry_d   = carry_q;
        old_d     = old_q;
        hold_d    = hold_q;
        start_d   = start_q;
        ctr_op    = CT_HOLD;
        ctr_val   = ld_addr_val;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_attr  = 1'b0;
        mem_wdata = '0;
        rd_valid  = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (ld_addr) begin
                    ctr_op  = CT_LOAD;
                    ctr_val = ld_addr_val;
                end
                if (start && op_known(cmd)) begin
                    job_d.op      = op_e'(cmd);
                    job_d.pattern = pattern;
                    job_d.mask    = mask;
                    job_d.amask   = attr_mask;
                    job_d.data    = wr_data;
                    job_d.rm_long = rm_long;
                    carry_d       = wr_data;
                    hold_d        = attr_mask;
                    case (op_e'(cmd))
                        OP_INSERT: state_d = S_AWR;
                        OP_WUM:    state_d = S_ARD;
                        default:   state_d = S_BRD;
                    endcase
                end
            end
            S_BRD: begin
                mem_req = 1'b1;
                if (mem_gnt) state_d = S_BEVAL;
            end
            S_BEVAL: begin
                case (job_q.op)
                    OP_CLEAR: state_d = hit ? S_FIN : S_BWR;
                    OP_SFWD: begin
                        if (hit) state_d = S_FIN;
                        else begin
                            ctr_op  = CT_INC;
                            state_d = (cursor == TOP_ADDR) ? S_FIN : S_BRD;
                        end
                    end
                    OP_SBWD: begin
                        if (hit) state_d = S_FIN;
                        else begin
                            ctr_op  = CT_DEC;
                            state_d = (cursor == '0) ? S_FIN : S_BRD;
                        end
                    end
                    OP_INSERT: begin
                        old_d   = mem_rdata;
                        state_d = S_BWR;
                    end
                    OP_RDMULT: begin
                        rd_valid = 1'b1;
                        ctr_op   = CT_INC;
                        state_d  = grp_end ? S_FIN : S_BRD;
                    end
                    default: state_d = S_FIN;
                endcase
            end
            S_BWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = (job_q.op == OP_INSERT) ? carry_q : '0;
                if (mem_gnt) begin
                    if (job_q.op == OP_INSERT) begin
                        if (old_null || cursor == TOP_ADDR) begin
                            ctr_op  = CT_LOAD;
                            ctr_val = start_q;
                            state_d = S_FIN;
                        end else begin
                            carry_d = old_q;
                            ctr_op  = CT_INC;
                            state_d = S_BRD;
                        end
                    end else begin
                        state_d = S_ARD;
                    end
                end
            end
            S_ARD: begin
                mem_req  = 1'b1;
                mem_attr = 1'b1;
                if (mem_gnt) state_d = S_AEVAL;
            end
            S_AEVAL: begin
                hold_d  = (job_q.op == OP_WUM) ? wum_merge(mem_rdata, job_q.amask, job_q.data)
                                               : attr_scrub(mem_rdata, job_q.amask);
                state_d = S_AWR;
            end
            S_AWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_attr  = 1'b1;
                mem_wdata = hold_q;
                if (mem_gnt) begin
                    case (job_q.op)
                        OP_CLEAR: begin
                            ctr_op  = CT_INC;
                            state_d = (cursor == TOP_ADDR) ? S_FIN : S_BRD;
                        end
                        OP_INSERT: begin
                            start_d = cursor;
                            state_d = S_BRD;
                        end
                        default: begin
                            ctr_op  = CT_INC;
                            state_d = S_FIN;
                        end
                    endcase
                end
            end
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            job_q   <= '0;
            carry_q <= '0;
            old_q   <= '0;
            hold_q  <= '0;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            job_q   <= job_d;
            carry_q <= carry_d;
            old_q   <= old_d;
            hold_q  <= hold_d;
            start_q <= start_d;
        end
    end

    assign mem_addr = cursor;
    assign rd_data  = mem_rdata;
    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_FIN);
    assign modified = busy && !done && op_modifies(job_q.op);

    // R14: an ungranted request is held unchanged
    assert_req_hold_R14: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_attr)));

    // R13: done is a single pulse followed by idle
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R13: modified only inside an operation
    assert_mod_in_busy_R13: assert property (@(posedge clk) disable iff (rst)
        modified |-> busy);

    // R13: memory requested only while working
    assert_req_in_busy_R13: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (busy && !done));

    // R12: burst bytes only from the non-modifying burst read
    assert_rdvalid_R12: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (busy && !modified && !mem_req));

    // R3: operands stay latched while an operation runs
    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(job_q));

endmodule

// File: tb/bufop_engine_bench.sv
`timescale 1ns/1ps
module bufop_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cmd = '0;
    logic [7:0]  pattern = '0, mask = '0, attr_mask = '0, wr_data = '0;
    logic        rm_long = 1'b0;
    logic        ld_addr = 1'b0;
    logic [11:0] ld_addr_val = '0;
    logic        mem_req, mem_we, mem_attr, mem_gnt;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        rd_valid, busy, modified, done;
    logic [7:0]  rd_data;
    logic [11:0] cursor;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0]  bmem [0:4095];
    logic [7:0]  amem [0:4095];
    logic [7:0]  rdq = '0;
    logic [1:0]  gcnt = '0;
    logic        fill_go = 1'b0, poke_go = 1'b0, poke_attr = 1'b0;
    logic [7:0]  fill_b = '0, fill_a = '0, poke_val = '0;
    logic [11:0] poke_addr = '0;
    logic [7:0]  rcap [0:31];
    int          rcnt;
    logic        mod_seen;

    always #2.5 clk = ~clk;

    assign mem_gnt   = (gcnt != 2'd2);
    assign mem_rdata = rdq;

    always @(posedge clk) begin
        gcnt <= gcnt + 2'd1;
        if (fill_go) begin
            for (int i = 0; i < 4096; i++) begin
                bmem[i] <= fill_b;
                amem[i] <= fill_a;
            end
        end else if (poke_go) begin
            if (poke_attr) amem[poke_addr] <= poke_val;
            else           bmem[poke_addr] <= poke_val;
        end
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                if (mem_attr) amem[mem_addr] <= mem_wdata;
                else          bmem[mem_addr] <= mem_wdata;
            end else begin
                rdq <= mem_attr ? amem[mem_addr] : bmem[mem_addr];
            end
        end
    end

    bufop_engine u_bufop_engine (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .pattern(pattern),
        .mask(mask), .attr_mask(attr_mask), .wr_data(wr_data), .rm_long(rm_long),
        .ld_addr(ld_addr), .ld_addr_val(ld_addr_val), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_attr(mem_attr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .modified(modified), .done(done), .cursor(cursor)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            fails = fails + 1;
            $display("FAIL R13 watchdog: actual cycles=%0d expected<190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] b, input logic [7:0] a);
        @(negedge clk); fill_b = b; fill_a = a; fill_go = 1'b1;
        @(negedge clk); fill_go = 1'b0;
    endtask

    task automatic poke(input logic is_attr, input logic [11:0] a, input logic [7:0] v);
        @(negedge clk); poke_attr = is_attr; poke_addr = a; poke_val = v; poke_go = 1'b1;
        @(negedge clk); poke_go = 1'b0;
    endtask

    task automatic load(input logic [11:0] a);
        @(negedge clk); ld_addr = 1'b1; ld_addr_val = a;
        @(negedge clk); ld_addr = 1'b0;
    endtask

    task automatic launch(input logic [2:0] c, input logic [7:0] p, input logic [7:0] m,
                          input logic [7:0] am, input logic [7:0] d, input logic rl);
        @(negedge clk);
        cmd = c; pattern = p; mask = m; attr_mask = am; wr_data = d; rm_long = rl;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_wait();
        int n = 0;
        rcnt = 0; mod_seen = 1'b0;
        while (!done && n < 40000) begin
            if (rd_valid && rcnt < 32) begin rcap[rcnt] = rd_data; rcnt = rcnt + 1; end
            if (modified) mod_seen = 1'b1;
            @(negedge clk); n = n + 1;
        end
        check("R13 done seen", {31'd0, done}, 32'd1);
        check("R13 modified low with done", {31'd0, modified}, 32'd0);
        @(negedge clk);
        check("R13 busy low after done", {31'd0, busy}, 32'd0);
    endtask

    task automatic run(input logic [2:0] c, input logic [7:0] p, input logic [7:0] m,
                       input logic [7:0] am, input logic [7:0] d, input logic rl);
        launch(c, p, m, am, d, rl);
        finish_wait();
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 modified", {31'd0, modified}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R1 cursor", {20'd0, cursor}, 32'd0);
        load(12'h2A7);
        check("R2 cursor load", {20'd0, cursor}, 32'h2A7);
    endtask

    task automatic t_search_fwd();
        fill(8'h41, 8'hFF);
        poke(1'b0, 12'h103, 8'h1A);
        poke(1'b0, 12'h105, 8'h5A);
        load(12'h100);
        run(3'd1, 8'h5A, 8'hFF, 8'h00, 8'h00, 1'b0);
        check("R7 full-mask match", {20'd0, cursor}, 32'h105);
        load(12'h100);
        run(3'd1, 8'h5A, 8'h1F, 8'h00, 8'h00, 1'b0);
        check("R4 partial-mask match", {20'd0, cursor}, 32'h103);
        load(12'h050);
        run(3'd1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
        check("R4 zero mask matches at once", {20'd0, cursor}, 32'h050);
        load(12'hFF0);
        run(3'd1, 8'h77, 8'hFF, 8'h00, 8'h00, 1'b0);
        check("R7 no match wraps to 0", {20'd0, cursor}, 32'h000);
        check("R13 search not modifying", {31'd0, mod_seen}, 32'd0);
    endtask

    task automatic t_search_bwd();
        fill(8'h41, 8'hFF);
        poke(1'b0, 12'h005, 8'h77);
        load(12'h00A);
        run(3'd2, 8'h77, 8'hFF, 8'h00, 8'h00, 1'b0);
        check("R8 backward match", {20'd0, cursor}, 32'h005);
        load(12'h004);
        run(3'd2, 8'h77, 8'hFF, 8'h00, 8'h00, 1'b0);
        check("R8 no match ends at FFF", {20'd0, cursor}, 32'hFFF);
    endtask

    task automatic t_clear();
        fill(8'h41, 8'hFF);
        poke(1'b0, 12'h215, 8'hC3);
        load(12'h210);
        run(3'd0, 8'h80, 8'h80, 8'h0F, 8'h00, 1'b0);
        check("R5 cursor at match", {20'd0, cursor}, 32'h215);
        check("R5 first cleared", {24'd0, bmem[12'h210]}, 32'h00);
        check("R5 last cleared", {24'd0, bmem[12'h214]}, 32'h00);
        check("R5 match kept", {24'd0, bmem[12'h215]}, 32'hC3);
        check("R6 attr scrubbed", {24'd0, amem[12'h212]}, 32'hF0);
        check("R6 attr at match kept", {24'd0, amem[12'h215]}, 32'hFF);
        check("R13 modified seen", {31'd0, mod_seen}, 32'd1);
        load(12'hFFC);
        run(3'd0, 8'h80, 8'h80, 8'h0F, 8'h00, 1'b0);
        check("R6 wrap stops at 0", {20'd0, cursor}, 32'h000);
        check("R6 top cleared", {24'd0, bmem[12'hFFF]}, 32'h00);
        check("R6 top attr scrubbed", {24'd0, amem[12'hFFF]}, 32'hF0);
        check("R6 location 0 untouched", {24'd0, bmem[12'h000]}, 32'h41);
    endtask

    task automatic t_insert();
        fill(8'h41, 8'hFF);
        poke(1'b0, 12'h300, 8'h11);
        poke(1'b0, 12'h301, 8'h22);
        poke(1'b0, 12'h302, 8'h33);
        poke(1'b0, 12'h303, 8'h00);
        poke(1'b0, 12'h304, 8'h44);
        load(12'h300);
        run(3'd3, 8'h00, 8'h00, 8'h5C, 8'h99, 1'b0);
        check("R9 new byte", {24'd0, bmem[12'h300]}, 32'h99);
        check("R9 shift 1", {24'd0, bmem[12'h301]}, 32'h11);
        check("R9 shift 3 over null", {24'd0, bmem[12'h303]}, 32'h33);
        check("R9 past null untouched", {24'd0, bmem[12'h304]}, 32'h44);
        check("R9 attr inserted", {24'd0, amem[12'h300]}, 32'h5C);
        check("R9 next attr untouched", {24'd0, amem[12'h301]}, 32'hFF);
        check("R9 cursor back at start", {20'd0, cursor}, 32'h300);
        poke(1'b0, 12'hFFE, 8'h12);
        poke(1'b0, 12'hFFF, 8'h34);
        load(12'hFFE);
        run(3'd3, 8'h00, 8'h00, 8'h5C, 8'h56, 1'b0);
        check("R10 start written", {24'd0, bmem[12'hFFE]}, 32'h56);
        check("R10 top shifted", {24'd0, bmem[12'hFFF]}, 32'h12);
        check("R10 location 0 untouched", {24'd0, bmem[12'h000]}, 32'h41);
        check("R10 cursor back at start", {20'd0, cursor}, 32'hFFE);
    endtask

    task automatic t_wum();
        fill(8'h41, 8'hFF);
        poke(1'b1, 12'h400, 8'hA5);
        load(12'h400);
        run(3'd4, 8'h00, 8'h00, 8'h0F, 8'h03, 1'b0);
        check("R11 merged attr", {24'd0, amem[12'h400]}, 32'hA3);
        check("R11 cursor advanced", {20'd0, cursor}, 32'h401);
        check("R11 char untouched", {24'd0, bmem[12'h400]}, 32'h41);
    endtask

    task automatic t_rdmult();
        fill(8'h41, 8'hFF);
        for (int i = 0; i < 40; i++) poke(1'b0, 12'h500 + 12'(i), 8'(i));
        load(12'h501);
        run(3'd5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
        check("R12 short count", rcnt, 32'd3);
        check("R12 short first", {24'd0, rcap[0]}, 32'h01);
        check("R12 short last", {24'd0, rcap[2]}, 32'h03);
        check("R12 short cursor", {20'd0, cursor}, 32'h504);
        load(12'h510);
        run(3'd5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1);
        check("R12 long count", rcnt, 32'd16);
        check("R12 long first", {24'd0, rcap[0]}, 32'h10);
        check("R12 long last", {24'd0, rcap[15]}, 32'h1F);
        check("R12 long cursor", {20'd0, cursor}, 32'h520);
    endtask

    task automatic t_ignore();
        fill(8'h41, 8'hFF);
        load(12'h001);
        launch(3'd1, 8'hEE, 8'hFF, 8'h00, 8'h00, 1'b0);
        repeat (20) @(negedge clk);
        cmd = 3'd0; mask = 8'h00; start = 1'b1; ld_addr = 1'b1; ld_addr_val = 12'h123;
        @(negedge clk);
        start = 1'b0; ld_addr = 1'b0;
        finish_wait();
        check("R3 running search unaffected", {20'd0, cursor}, 32'h000);
        check("R3 no clear launched", {24'd0, bmem[12'h123]}, 32'h41);
        repeat (5) @(negedge clk);
        check("R2 R3 stays idle", {31'd0, busy}, 32'd0);
        load(12'h0AB);
        launch(3'd6, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
        check("R3 reserved code ignored", {31'd0, busy}, 32'd0);
        check("R3 reserved keeps cursor", {20'd0, cursor}, 32'h0AB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_search_fwd();
        t_search_bwd();
        t_clear();
        t_insert();
        t_wum();
        t_rdmult();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule